// File: doc/BRIEF.md
# IN Endpoint Transaction Sequencer

This block runs the device side of one bulk-style IN endpoint. Each time the host's IN token reaches it, the block decides how to answer. It sends a STALL handshake when firmware has halted the endpoint. It sends a NAK handshake when the staging transmit buffer is not ready. Otherwise it streams one data packet from the staging buffer toward a downstream packet serializer. After the data packet it waits a bounded number of bit times for the host's handshake.

The read pointer of the RAM-backed FIFO behind the staging buffer is treated as a transaction:

- When the host acknowledges the packet, the block pulses a commit strobe, raises a success flag and releases the buffer lock.
- When the host stays silent, the block pulses a rewind strobe and raises a failure flag. The same bytes then go out again on the next IN token.
- When the staging buffer runs dry in the middle of a packet, the block asks the serializer to corrupt the packet on purpose. The host then times out and the rewind path follows.

Firmware arms the endpoint with a single-cycle enable pulse. This locks the buffer and lets the external fill logic begin its look-ahead fill. Firmware clears the two flags with their own clear pulses. Line coding, bit stuffing, CRC and token decoding are handled by other blocks.

Top module: `in_ep_seq`

## Requirements
- R1: After reset the lock, both flags, the interrupt request, every strobe and every stream or handshake valid output are low.
- R2: An IN token seen while `stall_i` is high yields exactly one handshake beat with `hs_stall_o`=1 (STALL). No data beat follows, the buffer is not popped, and the flags and strobes do not move.
- R3: An IN token while the endpoint is not both armed (lock high) and reporting `buf_ready_i` yields one handshake beat with `hs_stall_o`=0 (NAK). No data is popped.
- R4: An IN token with the endpoint ready sends min(`buf_len_i`, MAX_PKT) data beats. The bytes come in buffer order, one pop per accepted beat, and `tx_last_o` is high on the final beat only.
- R5: With `buf_len_i`=0 the packet is a single beat with `tx_zlp_o`=1, `tx_last_o`=1 and data 0, and the buffer is not popped.
- R6: An ACK after a clean data packet gives a one-cycle `commit_o`. The success flag is high and the lock low from the next cycle, unless `arm_i` re-arms in that same cycle.
- R7: When TIMEOUT_BITS bit ticks pass after the final beat with no ACK, a one-cycle `rewind_o` follows. The failure flag rises and the lock stays high, so the next IN token resends the same bytes.
- R8: If `buf_valid_i` is low while bytes remain in the packet, `tx_abort_o` pulses once and the packet ends. A later ACK is ignored, and the transaction closes through the rewind path.
- R9: `commit_o` and `rewind_o` are single-cycle pulses and never high in the same cycle.
- R10: `ts_clr_i` and `tf_clr_i` clear the success and failure flags independently. `irq_o` is high while either flag is set, and a set in the same cycle wins over a clear.
- R11: A pulse on `arm_i` sets the lock from the next cycle.
- R12: IN tokens that arrive while a transaction is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_in_i | input | 1 | Decoded IN token for this endpoint, one-cycle pulse |
| ack_i | input | 1 | Decoded ACK handshake from host, one-cycle pulse |
| bit_tick_i | input | 1 | One pulse per bus bit time |
| stall_i | input | 1 | Endpoint halt control |
| arm_i | input | 1 | Firmware transmit-enable pulse |
| ts_clr_i | input | 1 | Clear success flag |
| tf_clr_i | input | 1 | Clear failure flag |
| buf_ready_i | input | 1 | Look-ahead fill complete |
| buf_len_i | input | LW | Bytes staged for the packet |
| buf_data_i | input | DW | Byte at the head of the staging buffer |
| buf_valid_i | input | 1 | Head byte is present |
| buf_pop_o | output | 1 | Consume head byte |
| lock_o | output | 1 | Staging buffer locked |
| tx_valid_o | output | 1 | Data beat valid toward serializer |
| tx_data_o | output | DW | Data byte |
| tx_last_o | output | 1 | Final beat of packet |
| tx_zlp_o | output | 1 | Beat is a zero-length packet |
| tx_abort_o | output | 1 | Corrupt the packet (forced bit-stuff error) |
| tx_ready_i | input | 1 | Serializer accepts beat or handshake |
| hs_valid_o | output | 1 | Handshake request toward serializer |
| hs_stall_o | output | 1 | 1 = STALL, 0 = NAK |
| commit_o | output | 1 | FIFO read-pointer commit strobe |
| rewind_o | output | 1 | FIFO read-pointer rewind strobe |
| ts_flag_o | output | 1 | Transmit success flag |
| tf_flag_o | output | 1 | Transmit failure flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches these properties on every cycle:

- The two pointer strobes are exclusive, and each is a single-cycle pulse.
- A commit follows an ACK one cycle earlier.
- Each strobe raises its own flag in the next cycle.
- A commit drops the lock and a rewind keeps it.
- Handshakes and data beats never overlap.
- A zero-length beat pops nothing.
- An abort ends the stream.

Other behaviour only the bench scenarios can show, because it needs a model of the buffer contents and the FIFO pointers:

- The packet length and byte order.
- The clamp at the maximum packet size.
- Resending the same bytes after a rewind.
- The exact number of bit ticks before the timeout.
- An ACK being ignored after an aborted packet.
- Tokens being ignored while the block is busy.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_STALL  = 3'd2,
        ST_NAK    = 3'd3,
        ST_DATA   = 3'd4,
        ST_WAIT   = 3'd5,
        ST_COMMIT = 3'd6,
        ST_REWIND = 3'd7
    } seq_state_e;

endpackage

// File: rtl/in_ep_hs_timer.sv
// Handshake timeout: counts bit ticks while run_i is high and
// flags the tick that completes LIMIT of them.
module in_ep_hs_timer #(
    parameter int LIMIT = 18,
    localparam int TW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (!run_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (cnt_q == TW'(LIMIT - 1)) begin
                expire_o = 1'b1;
                cnt_d    = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/in_ep_flags.sv
// Success / failure flags with firmware clear; set has priority.
module in_ep_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ok_i,
    input  logic set_err_i,
    input  logic clr_ok_i,
    input  logic clr_err_i,
    output logic ok_o,
    output logic err_o,
    output logic irq_o
);
    typedef struct packed {
        logic ok;
        logic err;
    } flag_t;

    flag_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (clr_ok_i)  flg_d.ok  = 1'b0;
        if (clr_err_i) flg_d.err = 1'b0;
        if (set_ok_i)  flg_d.ok  = 1'b1;
        if (set_err_i) flg_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign ok_o  = flg_q.ok;
    assign err_o = flg_q.err;
    assign irq_o = flg_q.ok | flg_q.err;
endmodule

// File: rtl/in_ep_seq.sv
// Transaction sequencer for one IN endpoint.
module in_ep_seq
    import in_ep_pkg::*;
#(
    parameter int DW           = 8,
    parameter int MAX_PKT      = 64,
    parameter int TIMEOUT_BITS = 18,
    localparam int LW          = $clog2(MAX_PKT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_in_i,
    input  logic          ack_i,
    input  logic          bit_tick_i,
    input  logic          stall_i,
    input  logic          arm_i,
    input  logic          ts_clr_i,
    input  logic          tf_clr_i,
    input  logic          buf_ready_i,
    input  logic [LW-1:0] buf_len_i,
    input  logic [DW-1:0] buf_data_i,
    input  logic          buf_valid_i,
    output logic          buf_pop_o,
    output logic          lock_o,
    output logic          tx_valid_o,
    output logic [DW-1:0] tx_data_o,
    output logic          tx_last_o,
    output logic          tx_zlp_o,
    output logic          tx_abort_o,
    input  logic          tx_ready_i,
    output logic          hs_valid_o,
    output logic          hs_stall_o,
    output logic          commit_o,
    output logic          rewind_o,
    output logic          ts_flag_o,
    output logic          tf_flag_o,
    output logic          irq_o
);
    localparam logic [LW-1:0] MAX_LEN = LW'(MAX_PKT);

    typedef struct packed {
        seq_state_e      st;
        logic            lock;
        logic            bad;
        logic [LW-1:0]   rem;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;
    logic     hs_expired;
    logic     wait_run;

    assign wait_run = (seq_q.st == ST_WAIT);

    in_ep_hs_timer #(
        .LIMIT (TIMEOUT_BITS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (wait_run),
        .tick_i   (bit_tick_i),
        .expire_o (hs_expired)
    );

    in_ep_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ok_i  (commit_o),
        .set_err_i (rewind_o),
        .clr_ok_i  (ts_clr_i),
        .clr_err_i (tf_clr_i),
        .ok_o      (ts_flag_o),
        .err_o     (tf_flag_o),
        .irq_o     (irq_o)
    );

    always_comb begin
        seq_d      = seq_q;
        buf_pop_o  = 1'b0;
        tx_valid_o = 1'b0;
        tx_data_o  = '0;
        tx_last_o  = 1'b0;
        tx_zlp_o   = 1'b0;
        tx_abort_o = 1'b0;
        hs_valid_o = 1'b0;
        hs_stall_o = 1'b0;
        commit_o   = 1'b0;
        rewind_o   = 1'b0;

        unique case (seq_q.st)
            ST_IDLE: begin
                if (tok_in_i) seq_d.st = ST_CHECK;
            end
            ST_CHECK: begin
                if (stall_i) begin
                    seq_d.st = ST_STALL;
                end else if (!(seq_q.lock && buf_ready_i)) begin
                    seq_d.st = ST_NAK;
                end else begin
                    seq_d.st  = ST_DATA;
                    seq_d.bad = 1'b0;
                    seq_d.rem = (buf_len_i > MAX_LEN) ? MAX_LEN : buf_len_i;
                end
            end
            ST_STALL: begin
                hs_valid_o = 1'b1;
                hs_stall_o = 1'b1;
                if (tx_ready_i) seq_d.st = ST_IDLE;
            end
            ST_NAK: begin
                hs_valid_o = 1'b1;
                if (tx_ready_i) seq_d.st = ST_IDLE;
            end
            ST_DATA: begin
                if (seq_q.rem == '0) begin
                    tx_valid_o = 1'b1;
                    tx_zlp_o   = 1'b1;
                    tx_last_o  = 1'b1;
                    if (tx_ready_i) seq_d.st = ST_WAIT;
                end else if (!buf_valid_i) begin
                    tx_abort_o = 1'b1;
                    seq_d.bad  = 1'b1;
                    seq_d.st   = ST_WAIT;
                end else begin
                    tx_valid_o = 1'b1;
                    tx_data_o  = buf_data_i;
                    tx_last_o  = (seq_q.rem == LW'(1));
                    if (tx_ready_i) begin
                        buf_pop_o = 1'b1;
                        seq_d.rem = seq_q.rem - 1'b1;
                        if (seq_q.rem == LW'(1)) seq_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (ack_i && !seq_q.bad) seq_d.st = ST_COMMIT;
                else if (hs_expired)     seq_d.st = ST_REWIND;
            end
            ST_COMMIT: begin
                commit_o   = 1'b1;
                seq_d.lock = 1'b0;
                seq_d.st   = ST_IDLE;
            end
            ST_REWIND: begin
                rewind_o = 1'b1;
                seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase

        if (arm_i) seq_d.lock = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.lock <= 1'b0;
            seq_q.bad  <= 1'b0;
            seq_q.rem  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign lock_o = seq_q.lock;
endmodule

// File: rtl/in_ep_seq_chk.sv
module in_ep_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ack_i,
    input logic arm_i,
    input logic tx_ready_i,
    input logic buf_pop_o,
    input logic lock_o,
    input logic tx_valid_o,
    input logic tx_last_o,
    input logic tx_zlp_o,
    input logic tx_abort_o,
    input logic hs_valid_o,
    input logic commit_o,
    input logic rewind_o,
    input logic ts_flag_o,
    input logic tf_flag_o
);
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && rewind_o));
    p_commit_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
    p_rewind_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_o |=> !rewind_o);
    p_commit_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(ack_i));
    p_commit_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> ts_flag_o);
    p_commit_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && !arm_i) |=> !lock_o);
    p_rewind_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_o |=> tf_flag_o);
    p_rewind_keeps_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_o |=> lock_o);
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_valid_o && tx_valid_o));
    p_zlp_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_zlp_o |-> (tx_last_o && tx_valid_o && !buf_pop_o));
    p_pop_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop_o |-> (tx_valid_o && tx_ready_i));
    p_abort_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort_o |=> (!tx_valid_o && !tx_abort_o));
endmodule

bind in_ep_seq in_ep_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_i      (ack_i),
    .arm_i      (arm_i),
    .tx_ready_i (tx_ready_i),
    .buf_pop_o  (buf_pop_o),
    .lock_o     (lock_o),
    .tx_valid_o (tx_valid_o),
    .tx_last_o  (tx_last_o),
    .tx_zlp_o   (tx_zlp_o),
    .tx_abort_o (tx_abort_o),
    .hs_valid_o (hs_valid_o),
    .commit_o   (commit_o),
    .rewind_o   (rewind_o),
    .ts_flag_o  (ts_flag_o),
    .tf_flag_o  (tf_flag_o)
);

// File: tb/in_ep_seq_tb.sv
module in_ep_seq_tb;
    localparam int DW = 8;
    localparam int MAX_PKT = 64;
    localparam int TO_BITS = 18;
    localparam int LW = $clog2(MAX_PKT + 1);
    // event kinds
    localparam logic [1:0] EV_BEAT = 2'd0, EV_NAK = 2'd1, EV_STALL = 2'd2, EV_ABORT = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_in_i = 0, ack_i = 0, bit_tick_i = 0, stall_i = 0, arm_i = 0;
    logic ts_clr_i = 0, tf_clr_i = 0, buf_ready_i = 0, tx_ready_i = 1;
    logic [LW-1:0] buf_len_i = '0;
    logic [DW-1:0] buf_data_i;
    logic buf_valid_i;
    logic buf_pop_o, lock_o, tx_valid_o, tx_last_o, tx_zlp_o, tx_abort_o;
    logic hs_valid_o, hs_stall_o, commit_o, rewind_o, ts_flag_o, tf_flag_o, irq_o;
    logic [DW-1:0] tx_data_o;

    always #5 clk = ~clk;

    in_ep_seq #(.DW(DW), .MAX_PKT(MAX_PKT), .TIMEOUT_BITS(TO_BITS)) u_dut (.*);

    int nchk = 0, nbad = 0;
    int rd_ptr = 0, cm_ptr = 0;
    int commits = 0, rewinds = 0, both = 0;
    bit urun = 0;
    logic [1:0] tdiv = '0;
    logic [11:0] exp_q[$];
    string tag_q[$];

    function automatic logic [7:0] byte_at(int p);
        return 8'((p * 7 + 3) & 255);
    endfunction

    // staging buffer / FIFO model
    assign buf_data_i  = byte_at(rd_ptr);
    assign buf_valid_i = !urun || ((rd_ptr - cm_ptr) < 2);

    always @(posedge clk) begin
        tdiv <= tdiv + 1'b1;
        bit_tick_i <= (tdiv == 2'd2);
        if (rst_n) begin
            if (buf_pop_o) rd_ptr <= rd_ptr + 1;
            if (commit_o)  cm_ptr <= rd_ptr;
            if (rewind_o)  rd_ptr <= cm_ptr;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            logic [11:0] obs;
            bit have;
            have = 0;
            obs = '0;
            if (tx_valid_o && tx_ready_i) begin
                obs = {EV_BEAT, tx_zlp_o, tx_last_o, tx_data_o}; have = 1;
            end else if (hs_valid_o && tx_ready_i) begin
                obs = {(hs_stall_o ? EV_STALL : EV_NAK), 2'b00, 8'h00}; have = 1;
            end else if (tx_abort_o) begin
                obs = {EV_ABORT, 2'b00, 8'h00}; have = 1;
            end
            if (have) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R12", "unexpected stream event", int'(obs), -1);
                end else begin
                    logic [11:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(obs == e, t, "stream event", int'(obs), int'(e));
                end
            end
            if (commit_o) commits++;
            if (rewind_o) rewinds++;
            if (commit_o && rewind_o) both++;
        end
    end

    task automatic push(logic [1:0] k, bit z, bit l, logic [7:0] d, string t);
        exp_q.push_back({k, z, l, d});
        tag_q.push_back(t);
    endtask

    task automatic push_pkt(int n, string t);
        for (int i = 0; i < n; i++) push(EV_BEAT, 0, i == n - 1, byte_at(cm_ptr + i), t);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic pulse_tok();
        tok_in_i = 1; step(); tok_in_i = 0;
    endtask

    task automatic pulse_arm();
        arm_i = 1; step(); arm_i = 0;
    endtask

    task automatic pulse_ack();
        ack_i = 1; step(); ack_i = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) step();
    endtask

    task automatic wait_commit(int target);
        for (int i = 0; i < 400 && commits < target; i++) step();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) step();
        // R1 reset state
        chk(!lock_o && !ts_flag_o && !tf_flag_o && !irq_o, "R1", "lock/flags/irq", {lock_o, ts_flag_o, tf_flag_o, irq_o}, 0);
        chk(!tx_valid_o && !hs_valid_o && !commit_o && !rewind_o && !buf_pop_o && !tx_abort_o, "R1", "outputs idle",
            {tx_valid_o, hs_valid_o, commit_o, rewind_o, buf_pop_o, tx_abort_o}, 0);
        rst_n = 1;
        step();

        // R3: not armed -> NAK even though buffer claims ready
        buf_ready_i = 1; buf_len_i = LW'(4);
        push(EV_NAK, 0, 0, 8'h00, "R3");
        pulse_tok(); drain(); repeat (3) step();
        chk(rd_ptr == 0, "R3", "no pop on NAK", rd_ptr, 0);

        // R11: arm sets lock
        pulse_arm();
        chk(lock_o == 1, "R11", "lock after arm", lock_o, 1);

        // R3: armed but fill not complete -> NAK
        buf_ready_i = 0;
        push(EV_NAK, 0, 0, 8'h00, "R3");
        pulse_tok(); drain(); repeat (3) step();

        // R2: stall wins
        buf_ready_i = 1; stall_i = 1;
        push(EV_STALL, 0, 0, 8'h00, "R2");
        pulse_tok(); drain(); repeat (3) step();
        stall_i = 0;
        chk(rd_ptr == 0 && commits == 0 && rewinds == 0 && !ts_flag_o && !tf_flag_o, "R2", "stall side effects",
            rd_ptr + commits + rewinds, 0);

        // R4 + R6: oversize length clamps to MAX_PKT, then ACK
        buf_len_i = LW'(MAX_PKT + 6);
        push_pkt(MAX_PKT, "R4");
        pulse_tok(); drain(); repeat (2) step();
        pulse_ack(); wait_commit(1);
        chk(commits == 1, "R6", "commit count", commits, 1);
        chk(cm_ptr == MAX_PKT, "R4", "bytes consumed", cm_ptr, MAX_PKT);
        chk(ts_flag_o && irq_o && !lock_o, "R6", "flag/irq/unlock", {ts_flag_o, irq_o, lock_o}, 6);

        // R10: clear success flag
        ts_clr_i = 1; step(); ts_clr_i = 0;
        chk(!ts_flag_o && !irq_o, "R10", "ts clear", {ts_flag_o, irq_o}, 0);

        // R7 + R12: short packet, extra token while busy, no ACK -> rewind after timeout
        pulse_arm();
        buf_len_i = LW'(5);
        push_pkt(5, "R7");
        pulse_tok(); step(); pulse_tok();
        drain();
        begin
            int tc = 0;
            for (int i = 0; i < 400 && rewinds == 0; i++) begin
                if (bit_tick_i) tc++;
                step();
            end
            chk(tc == TO_BITS, "R7", "bit ticks until rewind", tc, TO_BITS);
        end
        chk(rewinds == 1 && commits == 1, "R12", "one rewind only", rewinds, 1);
        chk(tf_flag_o && lock_o && rd_ptr == cm_ptr, "R7", "tf/lock/rewound", {tf_flag_o, lock_o}, 3);
        // resend of identical bytes
        push_pkt(5, "R7");
        pulse_tok(); drain(); repeat (2) step();
        pulse_ack(); wait_commit(2);
        chk(cm_ptr == MAX_PKT + 5, "R7", "resent bytes committed", cm_ptr, MAX_PKT + 5);

        // R10: independent clear, irq follows remaining flag
        tf_clr_i = 1; step(); tf_clr_i = 0;
        chk(!tf_flag_o && ts_flag_o && irq_o, "R10", "tf clear keeps ts", {tf_flag_o, ts_flag_o, irq_o}, 3);
        ts_clr_i = 1; step(); ts_clr_i = 0;

        // R5: zero-length packet
        pulse_arm();
        buf_len_i = '0;
        push(EV_BEAT, 1, 1, 8'h00, "R5");
        pulse_tok(); drain(); repeat (2) step();
        pulse_ack(); wait_commit(3);
        chk(commits == 3 && rd_ptr == MAX_PKT + 5, "R5", "zlp commit no pop", rd_ptr, MAX_PKT + 5);

        // R8: underrun after two bytes, ACK ignored
        pulse_arm();
        buf_len_i = LW'(6); urun = 1;
        push(EV_BEAT, 0, 0, byte_at(cm_ptr), "R8");
        push(EV_BEAT, 0, 0, byte_at(cm_ptr + 1), "R8");
        push(EV_ABORT, 0, 0, 8'h00, "R8");
        pulse_tok(); drain(); repeat (2) step();
        pulse_ack();
        for (int i = 0; i < 400 && rewinds < 2; i++) step();
        urun = 0;
        chk(commits == 3 && rewinds == 2, "R8", "ack ignored, rewound", commits * 10 + rewinds, 32);
        chk(rd_ptr == cm_ptr && tf_flag_o, "R8", "pointer restored", rd_ptr, cm_ptr);

        repeat (5) step();
        chk(exp_q.size() == 0, "R4", "scoreboard empty", exp_q.size(), 0);
        chk(both == 0, "R9", "strobe overlap", both, 0);
        summary();
    end
endmodule